// File: doc/BRIEF.md
# Serial port interrupt status logic

This block sits beside one channel of a serial port and turns four channel conditions into sticky status bits, a per-condition enable mask and one shared interrupt output. The conditions are receive-data-present, transmit-register-empty, transmit-underflow and receive-overflow. The first two are levels held by the channel core until software reads the receive register or loads the transmit register. The last two are single-cycle strobes that need nothing done at their source.

Software reaches the block through a small register port with two registers: an enable register and a status register whose bits are cleared by writing 1. Status bits latch whenever their condition is seen, enabled or not, so the same bits serve both polled and interrupt-driven software. The interrupt output is a registered OR over the enabled status bits. Two hint inputs tell the block that the receive register is being read or the transmit register written in this cycle, so the matching level condition, which the core drops one cycle later, is not latched again from its stale value.

Top module: `sport_irq_status`

## Requirements
- R1: After reset the status register, the enable register and `irqOut` are all 0, and every read data bit above bit 3 reads 0.
- R2: Status bit mapping is bit 0 receive-data-present, bit 1 transmit-empty, bit 2 transmit-underflow, bit 3 receive-overflow; a condition seen at a clock edge sets its bit at that edge whatever the enable register holds, and a set bit stays set until software clears it.
- R3: `irqOut` at each clock edge takes the OR over the four bits of (status AND enable) as they stood before that edge, so it follows the registers one cycle late.
- R4: A write to address 0 clears each status bit whose write data bit is 1; when that bit was the only enabled set bit, `irqOut` falls on the following edge.
- R5: Writing 0 to a status bit leaves it unchanged, and writes to addresses 2 and 3 change no register.
- R6: When a condition and a write-1 clear hit the same status bit in the same cycle, the bit ends set.
- R7: A level condition (bits 0 and 1) still high when its bit is cleared sets the bit again at that same edge; a strobe condition (bits 2 and 3) stays cleared once cleared.
- R8: In a cycle where `rxRegRead` is high, the receive-data-present level does not set bit 0; in a cycle where `txRegWrite` is high, the transmit-empty level does not set bit 1; the hints have no effect on bits 2 and 3.
- R9: A write to address 1 loads bits 3:0 into the enable register, readable at address 1; a status bit already set when its enable is written raises `irqOut` one edge after the enable write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (2) | Register address: 0 status, 1 enable |
| regWrData | input | DATA_W (8) | Register write data |
| regRdData | output | DATA_W (8) | Register read data for `regAddr`, combinational |
| evtRxFull | input | 1 | Receive register holds unread data (level) |
| evtTxEmpty | input | 1 | Transmit register is empty (level) |
| evtTxUnder | input | 1 | Transmit underflow strobe |
| evtRxOver | input | 1 | Receive overflow strobe |
| rxRegRead | input | 1 | Receive data register is read this cycle |
| txRegWrite | input | 1 | Transmit data register is written this cycle |
| irqOut | output | 1 | Shared interrupt request, registered |

## Verification
A status bit stuck at 1 or dropped would show at once on a status read and, if enabled, as `irqOut` wrong one edge later; a set-versus-clear priority error shows only in the cycle where both meet, so the bench drives that collision on every bit. An enable register that loads the wrong bits shows on its own read-back and on the interrupt line one cycle after any matching status bit. Level and strobe conditions differ only after a clear with the source still active, which the bench checks on the edge of the clear itself.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;

  // Number of channel conditions handled
  localparam int NUM_EVT = 4;

  // Bit positions of the conditions in status and enable
  localparam int BIT_RX_FULL  = 0;
  localparam int BIT_TX_EMPTY = 1;
  localparam int BIT_TX_UNDER = 2;
  localparam int BIT_RX_OVER  = 3;

  // Conditions that are levels held by the source (1) versus strobes (0)
  localparam logic [NUM_EVT-1:0] EVT_LEVEL = 4'b0011;

  // Strobes from control to datapath
  typedef struct packed {
    logic               stsClr;   // write-1-clear to status this cycle
    logic               enLoad;   // load enable register this cycle
    logic [NUM_EVT-1:0] wrBits;   // write data bits for the registers
    logic [NUM_EVT-1:0] setBits;  // qualified hardware set per status bit
  } ctlStrobe_t;

endpackage

// File: rtl/sport_irq_ctrl.sv
module sport_irq_ctrl
  import sport_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 0,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 1
) (
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic [NUM_EVT-1:0] hintVec,
  output ctlStrobe_t         strb
);

  logic [NUM_EVT-1:0] setVec;

  // Level conditions are masked in the cycle their register is accessed,
  // since the source drops one cycle after the access.
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    if (EVT_LEVEL[i]) begin : g_level
      assign setVec[i] = evtVec[i] & ~hintVec[i];
    end else begin : g_pulse
      assign setVec[i] = evtVec[i];
    end
  end

  always_comb begin
    strb.stsClr  = regWrEn && (regAddr == STS_ADDR);
    strb.enLoad  = regWrEn && (regAddr == EN_ADDR);
    strb.wrBits  = regWrData[NUM_EVT-1:0];
    strb.setBits = setVec;
  end

endmodule

// File: rtl/sport_irq_dp.sv
module sport_irq_dp
  import sport_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 0,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);

  localparam int PAD_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] stsQ, stsD;
  logic [NUM_EVT-1:0] enQ, enD;
  logic               irqD;

  // Set wins over a software clear on the same bit.
  always_comb begin
    stsD = stsQ;
    if (strb.stsClr) stsD = stsD & ~strb.wrBits;
    stsD = stsD | strb.setBits;
    enD  = strb.enLoad ? strb.wrBits : enQ;
    irqD = |(stsQ & enQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ   <= '0;
      enQ    <= '0;
      irqOut <= 1'b0;
    end else begin
      stsQ   <= stsD;
      enQ    <= enD;
      irqOut <= irqD;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == STS_ADDR)     regRdData = {{PAD_W{1'b0}}, stsQ};
    else if (regAddr == EN_ADDR) regRdData = {{PAD_W{1'b0}}, enQ};
  end

  // R2: any qualified condition leaves its bit set after the edge
  a_r2_hw_set: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setBits != '0) |=> ((stsQ & $past(strb.setBits)) == $past(strb.setBits)));

  // R2: without a status write no bit ever falls
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.stsClr |=> ((stsQ & $past(stsQ)) == $past(stsQ)));

  // R4: write-1 bits with no concurrent set end cleared
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rstN)
    strb.stsClr |=> ((stsQ & $past(strb.wrBits & ~strb.setBits)) == '0));

  // R5: write-0 bits keep their value
  a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    strb.stsClr |=> ((stsQ & $past(stsQ & ~strb.wrBits)) == $past(stsQ & ~strb.wrBits)));

  // R3: line follows enabled status one cycle late
  a_r3_irq_hi: assert property (@(posedge clk) disable iff (!rstN)
    (|(stsQ & enQ)) |=> irqOut);
  a_r3_irq_lo: assert property (@(posedge clk) disable iff (!rstN)
    !(|(stsQ & enQ)) |=> !irqOut);

  // R9: enable register takes the written bits
  a_r9_en_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.enLoad |=> (enQ == $past(strb.wrBits)));

  // R1: unused read bits stay zero
  a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:NUM_EVT] == '0);

endmodule

// File: rtl/sport_irq_status.sv
module sport_irq_status
  import sport_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 0,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              evtRxFull,
  input  logic              evtTxEmpty,
  input  logic              evtTxUnder,
  input  logic              evtRxOver,
  input  logic              rxRegRead,
  input  logic              txRegWrite,
  output logic              irqOut
);

  logic [NUM_EVT-1:0] evtVec, hintVec;
  ctlStrobe_t         strb;

  always_comb begin
    evtVec                = '0;
    evtVec[BIT_RX_FULL]   = evtRxFull;
    evtVec[BIT_TX_EMPTY]  = evtTxEmpty;
    evtVec[BIT_TX_UNDER]  = evtTxUnder;
    evtVec[BIT_RX_OVER]   = evtRxOver;
    hintVec               = '0;
    hintVec[BIT_RX_FULL]  = rxRegRead;
    hintVec[BIT_TX_EMPTY] = txRegWrite;
  end

  sport_irq_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_ADDR(STS_ADDR), .EN_ADDR(EN_ADDR)
  ) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .evtVec   (evtVec),
    .hintVec  (hintVec),
    .strb     (strb)
  );

  sport_irq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_ADDR(STS_ADDR), .EN_ADDR(EN_ADDR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .regRdData(regRdData),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/sport_irq_status_bench.sv
`timescale 1ns/1ps
module sport_irq_status_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       evtRxFull = 1'b0, evtTxEmpty = 1'b0, evtTxUnder = 1'b0, evtRxOver = 1'b0;
  logic       rxRegRead = 1'b0, txRegWrite = 1'b0;
  logic       irqOut;

  int total = 0;
  int bad = 0;
  logic [3:0] expSts = 4'h0;
  logic [3:0] expEn = 4'h0;
  logic       expIrq = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sport_irq_status u_sport_irq_status (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtRxFull(evtRxFull), .evtTxEmpty(evtTxEmpty), .evtTxUnder(evtTxUnder),
    .evtRxOver(evtRxOver), .rxRegRead(rxRegRead), .txRegWrite(txRegWrite),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Read both registers and the line, compare with the model.
  task automatic checkAll(input string tag);
    regAddr = 2'd0; #1;
    check(tag, "status", regRdData, {4'h0, expSts});
    regAddr = 2'd1; #1;
    check(tag, "enable", regRdData, {4'h0, expEn});
    check(tag, "irq", {7'h0, irqOut}, {7'h0, expIrq});
  endtask

  // One cycle of stimulus, model update, then check. Called at a negedge.
  task automatic step(input logic [3:0] ev, input logic [1:0] hint, input logic wr,
                      input logic [1:0] addr, input logic [3:0] data, input string tag);
    logic [3:0] setV, clrV;
    evtRxFull = ev[0]; evtTxEmpty = ev[1]; evtTxUnder = ev[2]; evtRxOver = ev[3];
    rxRegRead = hint[0]; txRegWrite = hint[1];
    regWrEn = wr; regAddr = addr; regWrData = {4'hA, data};
    setV = ev & ~{2'b00, hint};
    clrV = (wr && addr == 2'd0) ? data : 4'h0;
    expIrq = |(expSts & expEn);
    expSts = setV | (expSts & ~clrV);
    if (wr && addr == 2'd1) expEn = data;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    {evtRxFull, evtTxEmpty, evtTxUnder, evtRxOver, rxRegRead, txRegWrite} = '0;
    checkAll(tag);
  endtask

  task automatic idle(input string tag);
    step(4'h0, 2'b00, 1'b0, 2'd0, 4'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state, including upper read bits at every address
    repeat (3) @(negedge clk);
    checkAll("R1");
    for (int a = 0; a < 4; a++) begin
      regAddr = 2'(a); #1;
      check("R1", "upper bits", {regRdData[7:4], 4'h0}, 8'h00);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2/R3: sweep every enable value against every condition pattern
    for (int en = 0; en < 16; en++) begin
      for (int ev = 0; ev < 16; ev++) begin
        step(4'h0, 2'b00, 1'b1, 2'd0, 4'hF, "R4");
        step(4'h0, 2'b00, 1'b1, 2'd1, 4'(en), "R9");
        step(4'(ev), 2'b00, 1'b0, 2'd0, 4'h0, "R2");
        idle("R3");
        idle("R3");
      end
    end

    // R4: clear each bit alone with only that bit enabled; line falls
    for (int b = 0; b < 4; b++) begin
      step(4'h0, 2'b00, 1'b1, 2'd1, 4'(1 << b), "R9");
      step(4'hF, 2'b00, 1'b0, 2'd0, 4'h0, "R2");
      idle("R3");
      step(4'h0, 2'b00, 1'b1, 2'd0, 4'(1 << b), "R4");
      idle("R4");
      check("R4", "irq after clear", {7'h0, irqOut}, 8'h00);
      step(4'h0, 2'b00, 1'b1, 2'd0, 4'hF, "R4");
    end

    // R5: write-0 and writes to unused addresses leave registers alone
    step(4'hF, 2'b00, 1'b1, 2'd1, 4'h5, "R9");
    for (int d = 0; d < 16; d++) begin
      step(4'h0, 2'b00, 1'b1, 2'd2, 4'(d), "R5");
      step(4'h0, 2'b00, 1'b1, 2'd3, 4'(d), "R5");
    end
    step(4'h0, 2'b00, 1'b1, 2'd0, 4'h0, "R5");
    step(4'h0, 2'b00, 1'b1, 2'd0, 4'h0, "R5");

    // R6: set and clear on the same bit in the same cycle
    for (int b = 0; b < 4; b++) begin
      step(4'h0, 2'b00, 1'b1, 2'd0, 4'hF, "R6");
      step(4'(1 << b), 2'b00, 1'b1, 2'd0, 4'hF, "R6");
      check("R6", "bit kept", {7'h0, expSts[b]}, 8'h01);
    end

    // R7: clear with sources still active, levels versus strobes
    step(4'h0, 2'b00, 1'b1, 2'd0, 4'hF, "R7");
    step(4'hF, 2'b00, 1'b0, 2'd0, 4'h0, "R7");
    for (int k = 0; k < 3; k++) begin
      evtRxFull = 1'b1; evtTxEmpty = 1'b1;
      step(4'h3, 2'b00, 1'b1, 2'd0, 4'hF, "R7");
    end
    step(4'h0, 2'b00, 1'b1, 2'd0, 4'hF, "R7");

    // R8: hints mask level sets only, in every combination
    for (int h = 0; h < 4; h++) begin
      for (int ev = 0; ev < 16; ev++) begin
        step(4'h0, 2'b00, 1'b1, 2'd0, 4'hF, "R8");
        step(4'(ev), 2'(h), 1'b1, 2'd0, 4'hF, "R8");
      end
    end

    // R9: stale status, then enable written, line rises one edge later
    step(4'h0, 2'b00, 1'b1, 2'd1, 4'h0, "R9");
    step(4'h0, 2'b00, 1'b1, 2'd0, 4'hF, "R9");
    step(4'h4, 2'b00, 1'b0, 2'd0, 4'h0, "R9");
    idle("R9");
    check("R9", "irq before enable", {7'h0, irqOut}, 8'h00);
    step(4'h0, 2'b00, 1'b1, 2'd1, 4'h4, "R9");
    idle("R9");
    check("R9", "irq after enable", {7'h0, irqOut}, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule